// File: doc/BRIEF.md
# Memory block access checker

This block guards a memory divided into equal-sized blocks. Each incoming request carries an address, a domain number, a secure flag, a privilege flag and an access kind (read, write or execute). The checker answers every accepted request, one cycle later, with an allow or deny decision. The answer comes from two pieces of configuration. The first is a 4-bit setting that each domain holds for each block. The second is a small set of eight policy words that all domains share.

The 4-bit block setting names one of the eight policy words and carries a separate bit that lets non-secure requests reach the block. A policy word is split into four permission groups, one for each combination of secure/non-secure and privileged/user. The request's own attributes pick one group, and that group must grant the requested access kind. Configuration is written and read through a simple word-wide register port. A global enable bit switches the checking on. While that bit is clear, every request is allowed.

Top module: `mbc_access_checker`

## Requirements
- R1: After reset, resp_valid is 0, req_ready is 1, and every configuration word reads back as 0. This covers the control word, the policy words and the block words.
- R2: Register map by word address. The control word is at 0x000, and only its bit 14 (enable) is stored; all other bits read as 0. Policy word k (k = 0..7) is at 0x008+k and stores bits 15:0, with bits 31:16 reading as 0. Block word w of domain d is at 0x400 + d*64 + w and stores all 32 bits. Unmapped addresses read as 0.
- R3: The setting for block n of a domain is held in that domain's block word n/8, at bits (n mod 8)*4 + 3 down to (n mod 8)*4. Bits 2:0 of the setting select the policy word, and bit 3 allows non-secure access. A block is the address range [n*4096, (n+1)*4096).
- R4: Layout of a policy word. Bits 15:12 hold the secure-privileged group, bits 11:8 the secure-user group, bits 7:4 the non-secure-privileged group and bits 3:0 the non-secure-user group. Within a group, bit 2 grants read, bit 1 grants write and bit 0 grants execute. The access kind is encoded 0 = read, 1 = write, 2 = execute. Code 3 is always denied while checking is enabled.
- R5: When checking is enabled, a secure request is allowed exactly when the group matching its privilege grants its access kind. The block's non-secure bit has no effect on secure requests.
- R6: When checking is enabled, a non-secure request is denied if the block's non-secure bit is clear, even when the selected group grants the access.
- R7: When checking is enabled, a request is denied if its domain number is 16 or more, or if its address lies at or beyond block 32.
- R8: While the enable bit is clear, every accepted request is answered with allow.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1. resp_valid rises on the next edge. req_ready equals (not resp_valid) or resp_ready. While resp_valid is 1 and resp_ready is 0, the response and its value hold unchanged.
- R10: Each domain has its own block words, while the eight policy words are shared by all domains. Changing a policy word changes the decisions for every domain that selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Byte address of the access |
| req_dom | input | 5 | Requesting domain number |
| req_secure | input | 1 | Request is secure |
| req_priv | input | 1 | Request is privileged |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| resp_valid | output | 1 | Decision valid |
| resp_ready | input | 1 | Consumer takes the decision |
| resp_allow | output | 1 | 1 = allowed, 0 = denied |

## Verification
The properties assume that the request attributes are stable while req_valid is high and req_ready is low. They also assume that the consumer of decisions asserts resp_ready at some point, so that responses drain. The directed stimulus sets every request field on a falling edge and removes req_valid once the request has been accepted. Configuration writes are kept out of cycles in which a request is accepted, so each decision depends only on settings written beforehand.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    // Register map regions (cfg_addr[11:10])
    localparam int CFG_AW       = 12;
    localparam int CTL_EN_BIT   = 14;
    localparam int POL_COUNT    = 8;
    localparam int WORD_BLOCKS  = 8;
    localparam int DOM_STRIDE   = 64;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_kind_e;

    // Per-block, per-domain setting
    typedef struct packed {
        logic       ns_ok;
        logic [2:0] pol_sel;
    } blk_nib_t;

    // Shared policy word: four permission groups
    typedef struct packed {
        logic [3:0] s_priv;
        logic [3:0] s_user;
        logic [3:0] ns_priv;
        logic [3:0] ns_user;
    } policy_t;

    function automatic logic [3:0] pick_group(policy_t p, logic sec, logic priv);
        logic [3:0] g;
        case ({sec, priv})
            2'b11:   g = p.s_priv;
            2'b10:   g = p.s_user;
            2'b01:   g = p.ns_priv;
            default: g = p.ns_user;
        endcase
        return g;
    endfunction

    function automatic logic group_grants(logic [3:0] g, acc_kind_e k);
        logic ok;
        case (k)
            ACC_RD:  ok = g[2];
            ACC_WR:  ok = g[1];
            ACC_EX:  ok = g[0];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mbc_cfg_regs.sv
module mbc_cfg_regs
    import mbc_pkg::*;
#(
    parameter int NUM_DOM = 16,
    parameter int NUM_BLK = 32,
    localparam int WORDS   = (NUM_BLK + WORD_BLOCKS - 1) / WORD_BLOCKS,
    localparam int WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int DIDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    localparam int BIDX_W  = $clog2(NUM_BLK)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 ctl_en,
    output policy_t [POL_COUNT-1:0] pol_o,
    input  logic [DIDX_W-1:0]    lk_dom,
    input  logic [BIDX_W-1:0]    lk_blk,
    output blk_nib_t             lk_nib
);

    logic              en_q;
    policy_t           pol_q  [POL_COUNT];
    logic [31:0]       blk_mem[NUM_DOM][WORDS];

    logic [1:0]        region;
    logic              is_ctl, is_pol, is_blk;
    logic [2:0]        pol_idx;
    logic [DIDX_W-1:0] wr_dom;
    logic [WIDX_W-1:0] wr_word;
    logic [WIDX_W-1:0] lk_word;
    logic [2:0]        lk_slot;
    logic [31:0]       lk_wordval;

    always_comb begin
        region  = cfg_addr[11:10];
        pol_idx = cfg_addr[2:0];
        wr_dom  = cfg_addr[6 +: DIDX_W];
        wr_word = cfg_addr[0 +: WIDX_W];
        is_ctl  = (region == 2'b00) && (cfg_addr[9:0] == 10'd0);
        is_pol  = (region == 2'b00) && (cfg_addr[9:3] == 7'd1);
        is_blk  = (region == 2'b01)
                  && ({1'b0, cfg_addr[9:6]} < 5'(NUM_DOM))
                  && ({1'b0, cfg_addr[5:0]} < 7'(WORDS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            for (int p = 0; p < POL_COUNT; p++) pol_q[p] <= '0;
            for (int d = 0; d < NUM_DOM; d++)
                for (int w = 0; w < WORDS; w++) blk_mem[d][w] <= '0;
        end else if (cfg_we) begin
            if (is_ctl) en_q <= cfg_wdata[CTL_EN_BIT];
            if (is_pol) pol_q[pol_idx] <= policy_t'(cfg_wdata[15:0]);
            if (is_blk) blk_mem[wr_dom][wr_word] <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (is_ctl)      cfg_rdata[CTL_EN_BIT] = en_q;
        else if (is_pol) cfg_rdata[15:0] = pol_q[pol_idx];
        else if (is_blk) cfg_rdata = blk_mem[wr_dom][wr_word];
    end

    generate
        for (genvar g = 0; g < POL_COUNT; g++) begin : g_pol_out
            assign pol_o[g] = pol_q[g];
        end
    endgenerate

    assign ctl_en     = en_q;
    assign lk_word    = lk_blk[BIDX_W-1:3];
    assign lk_slot    = lk_blk[2:0];
    assign lk_wordval = blk_mem[lk_dom][lk_word];
    assign lk_nib     = blk_nib_t'(lk_wordval[{lk_slot, 2'b00} +: 4]);

endmodule

// File: rtl/mbc_decide.sv
module mbc_decide
    import mbc_pkg::*;
(
    input  logic                    ctl_en,
    input  logic                    dom_ok,
    input  logic                    blk_ok,
    input  logic                    secure,
    input  logic                    priv,
    input  acc_kind_e               kind,
    input  blk_nib_t                nib,
    input  policy_t [POL_COUNT-1:0] pol_i,
    output logic                    allow
);

    policy_t    sel_pol;
    logic [3:0] grp;
    logic       ns_block;

    always_comb begin
        sel_pol  = pol_i[nib.pol_sel];
        grp      = pick_group(sel_pol, secure, priv);
        ns_block = !secure && !nib.ns_ok;
        if (!ctl_en)
            allow = 1'b1;
        else if (!dom_ok || !blk_ok || ns_block)
            allow = 1'b0;
        else
            allow = group_grants(grp, kind);
    end

endmodule

// File: rtl/mbc_resp_stage.sv
module mbc_resp_stage (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    input  logic allow_d,
    output logic resp_valid,
    input  logic resp_ready,
    output logic resp_allow
);

    logic valid_q, allow_q;

    assign req_ready  = !valid_q || resp_ready;
    assign resp_valid = valid_q;
    assign resp_allow = allow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            allow_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            valid_q <= 1'b1;
            allow_q <= allow_d;
        end else if (resp_ready) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mbc_access_checker.sv
module mbc_access_checker
    import mbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DOM_W     = 5,
    parameter int NUM_DOM   = 16,
    parameter int NUM_BLK   = 32,
    parameter int BLK_SHIFT = 12,
    localparam int DIDX_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    localparam int BIDX_W   = $clog2(NUM_BLK),
    localparam int BLKF_W   = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DOM_W-1:0]  req_dom,
    input  logic              req_secure,
    input  logic              req_priv,
    input  logic [1:0]        req_kind,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic              resp_allow
);

    localparam logic [BLKF_W-1:0] BLK_LIMIT = BLKF_W'(NUM_BLK);
    localparam logic [DOM_W-1:0]  DOM_LIMIT = DOM_W'(NUM_DOM);

    logic                    ctl_en;
    policy_t [POL_COUNT-1:0] pol;
    blk_nib_t                lk_nib;
    logic [BLKF_W-1:0]       blk_full;
    logic                    blk_ok, dom_ok, allow_d;

    assign blk_full = req_addr[ADDR_W-1:BLK_SHIFT];
    assign blk_ok   = blk_full < BLK_LIMIT;
    assign dom_ok   = req_dom < DOM_LIMIT;

    mbc_cfg_regs #(.NUM_DOM(NUM_DOM), .NUM_BLK(NUM_BLK)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl_en    (ctl_en),
        .pol_o     (pol),
        .lk_dom    (req_dom[DIDX_W-1:0]),
        .lk_blk    (blk_full[BIDX_W-1:0]),
        .lk_nib    (lk_nib)
    );

    mbc_decide u_decide (
        .ctl_en (ctl_en),
        .dom_ok (dom_ok),
        .blk_ok (blk_ok),
        .secure (req_secure),
        .priv   (req_priv),
        .kind   (acc_kind_e'(req_kind)),
        .nib    (lk_nib),
        .pol_i  (pol),
        .allow  (allow_d)
    );

    mbc_resp_stage u_resp (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .allow_d    (allow_d),
        .resp_valid (resp_valid),
        .resp_ready (resp_ready),
        .resp_allow (resp_allow)
    );

endmodule

// File: rtl/mbc_access_checker_sva.sv
module mbc_access_checker_sva #(
    parameter int NUM_DOM = 16,
    parameter int DOM_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [DOM_W-1:0] req_dom,
    input logic             req_secure,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic             resp_allow,
    input logic             ctl_en,
    input logic             nib_ns_ok
);

    logic acc;
    assign acc = req_valid && req_ready;

    a_r9_resp_follows_accept: assert property (@(posedge clk) disable iff (rst)
        acc |=> resp_valid);

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_allow)));

    a_r9_drain: assert property (@(posedge clk) disable iff (rst)
        (!acc && resp_valid && resp_ready) |=> !resp_valid);

    a_r8_disabled_allows: assert property (@(posedge clk) disable iff (rst)
        (acc && !ctl_en) |=> resp_allow);

    a_r7_bad_domain: assert property (@(posedge clk) disable iff (rst)
        (acc && ctl_en && (req_dom >= DOM_W'(NUM_DOM))) |=> !resp_allow);

    a_r6_ns_blocked: assert property (@(posedge clk) disable iff (rst)
        (acc && ctl_en && !req_secure && !nib_ns_ok) |=> !resp_allow);

endmodule

bind mbc_access_checker mbc_access_checker_sva #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_dom    (req_dom),
    .req_secure (req_secure),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_allow (resp_allow),
    .ctl_en     (ctl_en),
    .nib_ns_ok  (lk_nib.ns_ok)
);

// File: tb/tb_mbc_access_checker.sv
module tb_mbc_access_checker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_dom = '0;
    logic        req_secure = 1'b0;
    logic        req_priv = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b1;
    logic        resp_allow;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbc_access_checker dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dom(req_dom), .req_secure(req_secure), .req_priv(req_priv), .req_kind(req_kind),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_allow(resp_allow)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] blk_reg(int d, int w);
        return 12'(12'h400 + d*64 + w);
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic req_chk(string req, int d, int blk, bit sec, bit prv, int kind, bit exp);
        @(negedge clk);
        req_valid = 1'b1; resp_ready = 1'b1;
        req_dom = 5'(d); req_addr = 32'(blk) << 12; req_addr[7:0] = 8'h3c;
        req_secure = sec; req_priv = prv; req_kind = 2'(kind);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 32'(resp_valid), 32'd1);
        chk(req, 32'(resp_allow), 32'(exp));
    endtask

    task automatic t_reset;
        chk("R1 resp_valid", 32'(resp_valid), 0);
        chk("R1 req_ready", 32'(req_ready), 1);
        rd_chk("R1 control", 12'h000, 0);
        rd_chk("R1 policy7", 12'h00f, 0);
        rd_chk("R1 block word", blk_reg(15, 3), 0);
    endtask

    task automatic t_regs;
        wr(12'h000, 32'hffff_ffff);
        rd_chk("R2 control only bit 14", 12'h000, 32'h0000_4000);
        wr(12'h009, 32'h1234_5678);
        rd_chk("R2 policy low half", 12'h009, 32'h0000_5678);
        wr(blk_reg(3, 1), 32'hdead_beef);
        rd_chk("R2 block word", blk_reg(3, 1), 32'hdead_beef);
        rd_chk("R2 unmapped", 12'h800, 0);
        wr(blk_reg(3, 1), 32'h0);
        wr(12'h000, 32'h0);
    endtask

    task automatic t_disabled;
        req_chk("R8 disabled bad domain", 20, 0, 0, 0, 0, 1);
        req_chk("R8 disabled out of range", 1, 40, 0, 0, 3, 1);
    endtask

    task automatic t_setup;
        wr(12'h000, 32'h0000_4000);
        wr(12'h008, 32'h0000_7777);
        wr(12'h009, 32'h0000_7700);
        wr(12'h00b, 32'h0000_4421);
        // domain 2: blk0->pol1 secure only, blk1->pol0 NS clear, blk9->pol3 NS ok, blk31->pol0 NS ok
        wr(blk_reg(2, 0), 32'h0000_0001);
        wr(blk_reg(2, 1), 32'h0000_00b0);
        wr(blk_reg(2, 3), 32'h8000_0000);
    endtask

    task automatic t_secure;
        req_chk("R5 secure priv write pol1", 2, 0, 1, 1, 1, 1);
        req_chk("R5 secure user exec pol1", 2, 0, 1, 0, 2, 1);
        req_chk("R5 secure priv write denied pol3", 2, 9, 1, 1, 1, 0);
        req_chk("R5 secure priv read pol3", 2, 9, 1, 1, 0, 1);
    endtask

    task automatic t_groups;
        req_chk("R4 ns user exec", 2, 9, 0, 0, 2, 1);
        req_chk("R4 ns user read denied", 2, 9, 0, 0, 0, 0);
        req_chk("R4 ns priv write", 2, 9, 0, 1, 1, 1);
        req_chk("R4 reserved kind", 2, 9, 1, 1, 3, 0);
        req_chk("R3 top nibble blk31", 2, 31, 0, 0, 0, 1);
    endtask

    task automatic t_ns;
        req_chk("R6 ns bit clear blk1", 2, 1, 0, 1, 0, 0);
        req_chk("R6 secure same blk1", 2, 1, 1, 0, 0, 1);
        req_chk("R6 ns on secure-only blk0", 2, 0, 0, 1, 0, 0);
    endtask

    task automatic t_range;
        req_chk("R7 domain 16", 16, 31, 1, 1, 0, 0);
        req_chk("R7 block 32", 2, 32, 1, 1, 0, 0);
    endtask

    task automatic t_domains;
        req_chk("R10 dom5 ns denied", 5, 31, 0, 0, 0, 0);
        req_chk("R10 dom5 secure allowed", 5, 31, 1, 1, 0, 1);
        wr(12'h008, 32'h0000_0700);
        req_chk("R10 shared policy priv now denied", 5, 31, 1, 1, 0, 0);
        req_chk("R10 shared policy user allowed", 5, 31, 1, 0, 0, 1);
        req_chk("R10 dom2 sees new policy", 2, 31, 0, 0, 0, 0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        req_valid = 1'b1; resp_ready = 1'b0;
        req_dom = 5'd2; req_addr = 32'h0000_9000;
        req_secure = 1'b1; req_priv = 1'b1; req_kind = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 valid after accept", 32'(resp_valid), 1);
        chk("R9 ready low while stalled", 32'(req_ready), 0);
        chk("R9 allow value", 32'(resp_allow), 1);
        req_addr = 32'h0000_1000; req_secure = 1'b0;
        @(negedge clk);
        chk("R9 held valid", 32'(resp_valid), 1);
        chk("R9 held value", 32'(resp_allow), 1);
        resp_ready = 1'b1;
        #1;
        chk("R9 ready follows resp_ready", 32'(req_ready), 1);
        @(negedge clk);
        chk("R9 drained", 32'(resp_valid), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_disabled;
        t_setup;
        t_secure;
        t_groups;
        t_ns;
        t_range;
        t_domains;
        t_handshake;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule